// File: doc/BRIEF.md
# Counted and Pipelined Loop Branch Controller

This block decides the outcome of a loop-closing branch in hardware. It keeps two counters: a trip counter and a drain counter. Each branch event either takes the branch or lets it fall through. In the same cycle the block updates the counters and drives the strobes that a register file and a predicate file need to advance a software-pipelined loop. The strobes are the value for the first stage predicate and a rotate pulse.

There are two branch modes. In simple counted mode the trip counter steps down and the branch is taken while the counter is nonzero. A loaded value of N therefore gives N+1 passes through the loop body.

In pipelined counted mode the trip counter is spent first. While it lasts, the block feeds a 1 into the first stage predicate. After it runs out, the drain counter steps down and a 0 is fed in. Rotation moves each injected value up one stage per pass, so the later stages finish the iterations still in flight and the loop then exits on its own.

Software loads the counters through write ports. A write wins over a branch update in the same cycle.

Top module: `loop_branch_ctrl`

## Requirements
- R1: After reset both counters read 0 and taken, stagePred and rotate are 0.
- R2: In simple mode (brMode=0), a branch event with trip count nonzero asserts taken in that cycle and leaves the trip count one lower after the clock edge.
- R3: In simple mode, loading N into the trip counter gives exactly N taken branch events followed by one fall-through. A fall-through with trip count 0 leaves both counters unchanged.
- R4: In pipelined mode (brMode=1), a branch event with trip count nonzero asserts taken, stagePred=1 and rotate in that cycle. The trip count drops by one and the drain count is unchanged.
- R5: In pipelined mode with trip count 0 and drain count greater than 1, a branch event asserts taken and rotate with stagePred=0, and the drain count drops by one.
- R6: In pipelined mode with trip count 0 and drain count equal to 1, a branch event asserts rotate with taken=0 and stagePred=0, and the drain count becomes 0.
- R7: In pipelined mode with both counters 0, a branch event gives taken=0, rotate=0 and stagePred=0, and both counters stay 0.
- R8: A counter write (lcWrEn or ecWrEn) loads its data at the clock edge and wins over a same-cycle branch update of that counter. The outputs of that cycle are decided from the counter values before the write.
- R9: Without brValid, taken, stagePred and rotate are 0 and both counters hold their values unless written.
- R10: Simple mode never changes the drain count and never asserts rotate or stagePred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| brValid | input | 1 | Loop-closing branch event this cycle |
| brMode | input | 1 | Selects the branch mode: 0 is simple counted, 1 is pipelined counted |
| lcWrEn | input | 1 | Load the trip counter |
| lcWrData | input | 64 | Trip counter load value |
| ecWrEn | input | 1 | Load the drain counter |
| ecWrData | input | 64 | Drain counter load value |
| taken | output | 1 | Branch is taken (combinational with brValid) |
| stagePred | output | 1 | Value to inject into the first stage predicate |
| rotate | output | 1 | Advance register and predicate rotation |
| lcValue | output | 64 | Current trip count |
| ecValue | output | 64 | Current drain count |

## Verification
A branch update and a software load of the same counter can fall in the same cycle. That collision is where the write priority and the use of the pre-write value for the outputs could go wrong. The bench provokes the collision by asserting a counter write in the middle of an active pipelined loop and in the middle of a simple loop, with brValid still high. It judges the result on two points. The outputs of that cycle must come from the old count. One clock later the counter must read exactly the written value, with no decrement applied to it.

// File: rtl/loop_branch_pkg.sv
package loop_branch_pkg;
  typedef enum logic {
    MODE_SIMPLE = 1'b0,
    MODE_PIPE   = 1'b1
  } brMode_e;

  typedef struct packed {
    logic decLc;
    logic decEc;
    logic take;
    logic rot;
    logic pred;
  } loopStrobe_t;
endpackage

// File: rtl/loop_counters.sv
module loop_counters
  import loop_branch_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  loopStrobe_t      strobe,
  input  logic             lcWrEn,
  input  logic [CNT_W-1:0] lcWrData,
  input  logic             ecWrEn,
  input  logic [CNT_W-1:0] ecWrData,
  output logic [CNT_W-1:0] lcQ,
  output logic [CNT_W-1:0] ecQ,
  output logic             lcZero,
  output logic             ecZero,
  output logic             ecOne
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] lcNext;
  logic [CNT_W-1:0] ecNext;

  always_comb begin
    lcNext = lcQ;
    if (lcWrEn)            lcNext = lcWrData;
    else if (strobe.decLc) lcNext = lcQ - ONE;
  end

  always_comb begin
    ecNext = ecQ;
    if (ecWrEn)            ecNext = ecWrData;
    else if (strobe.decEc) ecNext = ecQ - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lcQ <= '0;
      ecQ <= '0;
    end else begin
      lcQ <= lcNext;
      ecQ <= ecNext;
    end
  end

  assign lcZero = (lcQ == '0);
  assign ecZero = (ecQ == '0);
  assign ecOne  = (ecQ == ONE);

  // R2 / R4: a granted decrement lowers the trip count by exactly one
  a_r2_lc_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decLc && !lcWrEn) |=> (lcQ == $past(lcQ) - ONE));

  // R5 / R6: a granted drain step lowers the drain count by exactly one
  a_r5_ec_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decEc && !ecWrEn) |=> (ecQ == $past(ecQ) - ONE));

  // R8: a write wins over any branch update
  a_r8_wr_wins: assert property (@(posedge clk) disable iff (!rstN)
    lcWrEn |=> (lcQ == $past(lcWrData)));

  // R9: no write and no decrement leaves the drain count unchanged
  a_r9_ec_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.decEc && !ecWrEn) |=> $stable(ecQ));
endmodule

// File: rtl/loop_decide.sv
module loop_decide
  import loop_branch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        brValid,
  input  brMode_e     brMode,
  input  logic        lcZero,
  input  logic        ecZero,
  input  logic        ecOne,
  output loopStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (brValid) begin
      if (!lcZero) begin
        strobe.decLc = 1'b1;
        strobe.take  = 1'b1;
        if (brMode == MODE_PIPE) begin
          strobe.pred = 1'b1;
          strobe.rot  = 1'b1;
        end
      end else if (brMode == MODE_PIPE && !ecZero) begin
        strobe.decEc = 1'b1;
        strobe.rot   = 1'b1;
        strobe.take  = !ecOne;
      end
    end
  end

  // R4: a 1 is injected only while trips remain
  a_r4_pred_needs_trip: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pred |-> !lcZero);

  // R7: both counters spent means a quiet fall-through
  a_r7_rest_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && lcZero && ecZero) |-> (!strobe.rot && !strobe.take));

  // R10: simple mode never rotates or touches the drain counter
  a_r10_simple_norot: assert property (@(posedge clk) disable iff (!rstN)
    (brMode == MODE_SIMPLE) |-> (!strobe.rot && !strobe.decEc));

  // R9: no branch event means no strobes
  a_r9_idle: assert property (@(posedge clk) disable iff (!rstN)
    !brValid |-> (strobe == '0));
endmodule

// File: rtl/loop_branch_ctrl.sv
module loop_branch_ctrl
  import loop_branch_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             brValid,
  input  logic             brMode,
  input  logic             lcWrEn,
  input  logic [CNT_W-1:0] lcWrData,
  input  logic             ecWrEn,
  input  logic [CNT_W-1:0] ecWrData,
  output logic             taken,
  output logic             stagePred,
  output logic             rotate,
  output logic [CNT_W-1:0] lcValue,
  output logic [CNT_W-1:0] ecValue
);
  loopStrobe_t strobe;
  logic        lcZero;
  logic        ecZero;
  logic        ecOne;

  loop_decide u_decide (
    .clk     (clk),
    .rstN    (rstN),
    .brValid (brValid),
    .brMode  (brMode_e'(brMode)),
    .lcZero  (lcZero),
    .ecZero  (ecZero),
    .ecOne   (ecOne),
    .strobe  (strobe)
  );

  loop_counters #(.CNT_W(CNT_W)) u_counters (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .lcWrEn   (lcWrEn),
    .lcWrData (lcWrData),
    .ecWrEn   (ecWrEn),
    .ecWrData (ecWrData),
    .lcQ      (lcValue),
    .ecQ      (ecValue),
    .lcZero   (lcZero),
    .ecZero   (ecZero),
    .ecOne    (ecOne)
  );

  assign taken     = strobe.take;
  assign stagePred = strobe.pred;
  assign rotate    = strobe.rot;

  // R6: the last drain step rotates but falls through
  a_r6_last_drain: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && brMode && lcZero && ecOne) |-> (rotate && !taken && !stagePred));
endmodule

// File: tb/loop_branch_ctrl_tb.sv
module loop_branch_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        brValid = 1'b0;
  logic        brMode = 1'b0;
  logic        lcWrEn = 1'b0;
  logic [63:0] lcWrData = '0;
  logic        ecWrEn = 1'b0;
  logic [63:0] ecWrData = '0;
  logic        taken, stagePred, rotate;
  logic [63:0] lcValue, ecValue;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [63:0] mLc = '0;
  logic [63:0] mEc = '0;
  int takenCount = 0;

  always #2 clk = ~clk;

  loop_branch_ctrl dut_i (
    .clk(clk), .rstN(rstN), .brValid(brValid), .brMode(brMode),
    .lcWrEn(lcWrEn), .lcWrData(lcWrData), .ecWrEn(ecWrEn), .ecWrData(ecWrData),
    .taken(taken), .stagePred(stagePred), .rotate(rotate),
    .lcValue(lcValue), .ecValue(ecValue)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare outputs and counters against the model, advance model.
  task automatic step(input bit v, input bit m, input bit lw, input logic [63:0] ld,
                      input bit ew, input logic [63:0] ed);
    bit eTake, ePred, eRot, dLc, dEc;
    string tag;
    @(negedge clk);
    brValid = v; brMode = m; lcWrEn = lw; lcWrData = ld; ecWrEn = ew; ecWrData = ed;
    eTake = 0; ePred = 0; eRot = 0; dLc = 0; dEc = 0; tag = "R9";
    if (v) begin
      if (!m) begin
        tag = (mLc != 0) ? "R2" : "R3";
        if (mLc != 0) begin eTake = 1; dLc = 1; end
      end else if (mLc != 0) begin
        tag = "R4"; eTake = 1; ePred = 1; eRot = 1; dLc = 1;
      end else if (mEc > 1) begin
        tag = "R5"; eTake = 1; eRot = 1; dEc = 1;
      end else if (mEc == 1) begin
        tag = "R6"; eRot = 1; dEc = 1;
      end else tag = "R7";
    end
    if (lw || ew) tag = "R8";
    #1;
    chk(tag, "taken", {63'b0, taken}, {63'b0, eTake});
    chk(tag, "stagePred", {63'b0, stagePred}, {63'b0, ePred});
    chk(tag, "rotate", {63'b0, rotate}, {63'b0, eRot});
    chk(tag, "lcValue", lcValue, mLc);
    chk(m ? tag : "R10", "ecValue", ecValue, mEc);
    if (eTake) takenCount++;
    if (lw) mLc = ld; else if (dLc) mLc = mLc - 1;
    if (ew) mEc = ed; else if (dEc) mEc = mEc - 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "lcValue", lcValue, 0);
    chk("R1", "ecValue", ecValue, 0);
    chk("R1", "taken", {63'b0, taken}, 0);
    chk("R1", "rotate", {63'b0, rotate}, 0);
    rstN = 1'b1;
    step(0, 0, 0, 0, 0, 0);
    // Simple loop: load 5 -> 5 taken, then fall through (6 passes)
    step(0, 0, 1, 5, 1, 9);
    takenCount = 0;
    for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 0, 0);
    chk("R3", "taken count for load 5", takenCount, 5);
    // idle holds
    step(0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    // Pipelined: 3 trips, drain 3
    step(0, 1, 1, 3, 1, 3);
    takenCount = 0;
    for (int i = 0; i < 8; i++) step(1, 1, 0, 0, 0, 0);
    chk("R6", "pipelined taken count", takenCount, 5);
    // Collision: write during active pipelined branch
    step(0, 1, 1, 4, 1, 2);
    step(1, 1, 0, 0, 0, 0);
    step(1, 1, 1, 10, 0, 0);
    step(1, 1, 0, 0, 1, 7);
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0, 0);
    // Collision in simple mode
    step(1, 0, 1, 2, 0, 0);
    step(1, 0, 1, 1, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0);
    // Pipelined with zero trips and drain 1
    step(0, 1, 1, 0, 1, 1);
    step(1, 1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0);
    // Large count boundary
    step(0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 64'h8000_0000_0000_0000);
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule